// File: doc/BRIEF.md
# Half-Duplex Differential Line Transceiver Controller

This block is the digital control core of a half-duplex differential bus transceiver. On the transmit side, a drive-enable and a data bit set two complementary line outputs, each with its own output-enable so it can go high impedance. On the receive side, the block takes a signed, digitized differential line voltage in millivolts and a flag that reports disconnected inputs. It decides the received bit and presents it behind an active-low receiver enable.

The receiver's decision band lies wholly below zero. Its upper edge is at -30 mV and its lower edge at -200 mV, so an idle, terminated bus that decays to 0 V reads as a logic high without bias resistors. Inside the band the previous decision is held, which gives hysteresis instead of an undefined output. A digitized die temperature in degrees Celsius feeds a shutdown flag with hysteresis. The flag disables the line driver at 150 °C and releases it only at 140 °C. The receiver keeps working throughout. Analog drivers, comparators and sensors are outside the block; their quantities arrive as codes.

Top module: `rs485_xcvr_ctrl`

## Requirements
- R1: While `de` is 1 and `tsd` is 0, `y_oe` and `z_oe` are 1, `y` equals `txd` and `z` equals the inverse of `txd`, in the same cycle.
- R2: While `de` is 0, `y_oe` and `z_oe` are 0 in the same cycle, whatever `txd` is.
- R3: When `rx_open` is 0 and `diff_mv` is at or above -30 (including exactly 0), `rxd` is 1 after the next rising clock edge.
- R4: When `rx_open` is 0 and `diff_mv` is at or below -200, `rxd` is 0 after the next rising clock edge.
- R5: When `rx_open` is 0 and `diff_mv` is strictly between -200 and -30, `rxd` keeps the value it had before that clock edge.
- R6: When `rx_open` is 1, `rxd` is 1 after the next rising clock edge, whatever `diff_mv` is.
- R7: `rxd_oe` is the inverse of `re` in the same cycle. The receiver decision keeps updating while `re` is 1, so it is current once `re` returns to 0.
- R8: When `temp_c` is 150 or more, `tsd` is 1 after the next rising clock edge.
- R9: Once set, `tsd` stays 1 while `temp_c` is above 140 and clears at the edge after `temp_c` is 140 or less. While clear, it stays 0 for any `temp_c` below 150.
- R10: While `tsd` is 1, `y_oe` and `z_oe` are 0 whatever `de` is, and the receiver behaves as in R3 to R7.
- R11: During and right after reset, `tsd` is 0 and `rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de | input | 1 | Driver enable |
| txd | input | 1 | Transmit data bit |
| y | output | 1 | Non-inverting line output value |
| y_oe | output | 1 | Output enable for `y` (0 = high impedance) |
| z | output | 1 | Inverting line output value |
| z_oe | output | 1 | Output enable for `z` (0 = high impedance) |
| diff_mv | input | DIFF_W (12) | Signed two's-complement differential voltage in mV |
| rx_open | input | 1 | Receiver inputs disconnected |
| re | input | 1 | Active-low receiver enable |
| rxd | output | 1 | Received data bit |
| rxd_oe | output | 1 | Output enable for `rxd` (0 = high impedance) |
| temp_c | input | TEMP_W (8) | Unsigned die temperature in °C |
| tsd | output | 1 | Thermal shutdown flag |

## Verification
Thermal shutdown and a receiver decision can land on the same clock edge. So can a shutdown release and a change of `de`. The bench provokes both: in one stimulus cycle it drives `temp_c` to the trip value, `diff_mv` across a threshold and `de` high. It then checks that the driver enables drop exactly one edge later while `rxd` takes its new value on that same edge. A bench-side model of both hysteresis loops judges every cycle of the full threshold and temperature sweeps.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

   typedef enum logic [1:0] {
      ZONE_MARK  = 2'd0,
      ZONE_SPACE = 2'd1,
      ZONE_GAP   = 2'd2
   } rx_zone_e;

   typedef struct packed {
      logic y;
      logic z;
      logic en;
   } drv_out_t;

endpackage

// File: rtl/rs485_thermal.sv
module rs485_thermal #(
   parameter int TEMP_W   = 8,
   parameter int TRIP_C   = 150,
   parameter int RESUME_C = 140
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_c,
   output logic              shutdown
);
   localparam int TEMP_MAX = (1 << TEMP_W) - 1;

   initial begin
      assert (TRIP_C <= TEMP_MAX) else $error("trip point beyond temperature code range");
      assert (RESUME_C < TRIP_C)  else $error("resume point must lie below trip point");
      assert (RESUME_C >= 0)      else $error("resume point must be non-negative");
   end

   logic sd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sd_q <= 1'b0;
      else if (32'(temp_c) >= TRIP_C)
         sd_q <= 1'b1;
      else if (32'(temp_c) <= RESUME_C)
         sd_q <= 1'b0;
   end

   assign shutdown = sd_q;
endmodule

// File: rtl/rs485_rx.sv
module rs485_rx
   import rs485_pkg::*;
#(
   parameter int DIFF_W    = 12,
   parameter int UPPER_MV  = -30,
   parameter int LOWER_MV  = -200,
   parameter bit HOLD_BAND = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DIFF_W-1:0] diff_mv,
   input  logic                     rx_open,
   output logic                     level
);
   localparam int DIFF_MIN = -(1 << (DIFF_W - 1));

   initial begin
      assert (LOWER_MV < UPPER_MV) else $error("lower threshold must sit below upper threshold");
      assert (UPPER_MV < 0)        else $error("upper threshold must be negative for idle-high");
      assert (LOWER_MV > DIFF_MIN) else $error("lower threshold outside input code range");
   end

   rx_zone_e zone;
   logic     level_q;
   logic     level_d;

   always_comb begin
      if (rx_open)
         zone = ZONE_MARK;
      else if (32'(diff_mv) >= UPPER_MV)
         zone = ZONE_MARK;
      else if (32'(diff_mv) <= LOWER_MV)
         zone = ZONE_SPACE;
      else
         zone = ZONE_GAP;
   end

   generate
      if (HOLD_BAND) begin : g_hold
         always_comb begin
            unique case (zone)
               ZONE_MARK:  level_d = 1'b1;
               ZONE_SPACE: level_d = 1'b0;
               default:    level_d = level_q;
            endcase
         end
      end else begin : g_single
         always_comb begin
            level_d = (zone == ZONE_MARK);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_q <= 1'b1;
      else
         level_q <= level_d;
   end

   assign level = level_q;
endmodule

// File: rtl/rs485_drv.sv
module rs485_drv
   import rs485_pkg::*;
(
   input  logic     de,
   input  logic     txd,
   input  logic     shutdown,
   output drv_out_t pins
);
   always_comb begin
      pins.en = de & ~shutdown;
      pins.y  = pins.en & txd;
      pins.z  = pins.en & ~txd;
   end
endmodule

// File: rtl/rs485_xcvr_ctrl.sv
module rs485_xcvr_ctrl
   import rs485_pkg::*;
#(
   parameter int DIFF_W    = 12,
   parameter int TEMP_W    = 8,
   parameter int UPPER_MV  = -30,
   parameter int LOWER_MV  = -200,
   parameter int TRIP_C    = 150,
   parameter int RESUME_C  = 140,
   parameter bit HOLD_BAND = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     de,
   input  logic                     txd,
   output logic                     y,
   output logic                     y_oe,
   output logic                     z,
   output logic                     z_oe,
   input  logic signed [DIFF_W-1:0] diff_mv,
   input  logic                     rx_open,
   input  logic                     re,
   output logic                     rxd,
   output logic                     rxd_oe,
   input  logic [TEMP_W-1:0]        temp_c,
   output logic                     tsd
);
   initial begin
      assert (DIFF_W >= 9 && DIFF_W <= 24) else $error("DIFF_W out of supported range");
      assert (TEMP_W >= 2 && TEMP_W <= 16) else $error("TEMP_W out of supported range");
   end

   drv_out_t drv_pins;
   logic     sd;
   logic     rx_level;

   rs485_thermal #(
      .TEMP_W   (TEMP_W),
      .TRIP_C   (TRIP_C),
      .RESUME_C (RESUME_C)
   ) u_thermal (
      .clk      (clk),
      .rst_n    (rst_n),
      .temp_c   (temp_c),
      .shutdown (sd)
   );

   rs485_drv u_drv (
      .de       (de),
      .txd      (txd),
      .shutdown (sd),
      .pins     (drv_pins)
   );

   rs485_rx #(
      .DIFF_W    (DIFF_W),
      .UPPER_MV  (UPPER_MV),
      .LOWER_MV  (LOWER_MV),
      .HOLD_BAND (HOLD_BAND)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .diff_mv (diff_mv),
      .rx_open (rx_open),
      .level   (rx_level)
   );

   assign y      = drv_pins.y;
   assign z      = drv_pins.z;
   assign y_oe   = drv_pins.en;
   assign z_oe   = drv_pins.en;
   assign rxd    = rx_level;
   assign rxd_oe = ~re;
   assign tsd    = sd;
endmodule

// File: rtl/rs485_chk.sv
module rs485_chk #(
   parameter int DIFF_W    = 12,
   parameter int TEMP_W    = 8,
   parameter int UPPER_MV  = -30,
   parameter int LOWER_MV  = -200,
   parameter int TRIP_C    = 150,
   parameter int RESUME_C  = 140,
   parameter bit HOLD_BAND = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     de,
   input logic                     txd,
   input logic                     y,
   input logic                     y_oe,
   input logic                     z,
   input logic                     z_oe,
   input logic signed [DIFF_W-1:0] diff_mv,
   input logic                     rx_open,
   input logic                     re,
   input logic                     rxd,
   input logic                     rxd_oe,
   input logic [TEMP_W-1:0]        temp_c,
   input logic                     tsd
);
   logic in_mark, in_space, in_gap;
   assign in_mark  = rx_open || (32'(diff_mv) >= UPPER_MV);
   assign in_space = !rx_open && (32'(diff_mv) <= LOWER_MV);
   assign in_gap   = !in_mark && !in_space;

   AST_DRV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (de && !tsd) |-> (y_oe && z_oe && y == txd && z == !txd)); // R1
   AST_DRV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (!y_oe && !z_oe)); // R2
   AST_RX_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_open && 32'(diff_mv) >= UPPER_MV) |=> rxd); // R3
   AST_RX_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      in_space |=> !rxd); // R4
   generate
      if (HOLD_BAND) begin : g_hold_chk
         AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            in_gap |=> (rxd == $past(rxd))); // R5
      end
   endgenerate
   AST_RX_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_open |=> rxd); // R6
   AST_RX_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      rxd_oe == !re); // R7
   AST_TSD_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(temp_c) >= TRIP_C) |=> tsd); // R8
   AST_TSD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tsd && 32'(temp_c) > RESUME_C) |=> tsd); // R9
   AST_TSD_STAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!tsd && 32'(temp_c) < TRIP_C) |=> !tsd); // R9
   AST_TSD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      tsd |-> (!y_oe && !z_oe)); // R10
endmodule

bind rs485_xcvr_ctrl rs485_chk #(
   .DIFF_W    (DIFF_W),
   .TEMP_W    (TEMP_W),
   .UPPER_MV  (UPPER_MV),
   .LOWER_MV  (LOWER_MV),
   .TRIP_C    (TRIP_C),
   .RESUME_C  (RESUME_C),
   .HOLD_BAND (HOLD_BAND)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .de      (de),
   .txd     (txd),
   .y       (y),
   .y_oe    (y_oe),
   .z       (z),
   .z_oe    (z_oe),
   .diff_mv (diff_mv),
   .rx_open (rx_open),
   .re      (re),
   .rxd     (rxd),
   .rxd_oe  (rxd_oe),
   .temp_c  (temp_c),
   .tsd     (tsd)
);

// File: tb/test_rs485_xcvr_ctrl.sv
`timescale 1ns/1ps
module test_rs485_xcvr_ctrl;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              de = 1'b0, txd = 1'b0, rx_open = 1'b0, re = 1'b0;
   logic signed [11:0] diff_mv = '0;
   logic [7:0]        temp_c = 8'd25;
   logic              y, y_oe, z, z_oe, rxd, rxd_oe, tsd;

   int checks = 0;
   int failures = 0;
   logic exp_rx = 1'b1;
   logic exp_tsd = 1'b0;

   always #2.5 clk = ~clk;

   rs485_xcvr_ctrl i_rs485_xcvr_ctrl (
      .clk(clk), .rst_n(rst_n), .de(de), .txd(txd),
      .y(y), .y_oe(y_oe), .z(z), .z_oe(z_oe),
      .diff_mv(diff_mv), .rx_open(rx_open), .re(re),
      .rxd(rxd), .rxd_oe(rxd_oe), .temp_c(temp_c), .tsd(tsd)
   );

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic check_comb();
      logic en;
      en = de & ~exp_tsd;
      if (exp_tsd) begin
         chk("R10 y_oe", int'(y_oe), 0);
         chk("R10 z_oe", int'(z_oe), 0);
      end else if (de) begin
         chk("R1 y_oe", int'(y_oe), 1);
         chk("R1 z_oe", int'(z_oe), 1);
         chk("R1 y", int'(y), int'(txd));
         chk("R1 z", int'(z), int'(!txd));
      end else begin
         chk("R2 y_oe", int'(y_oe), int'(en));
         chk("R2 z_oe", int'(z_oe), int'(en));
      end
      chk("R7 rxd_oe", int'(rxd_oe), int'(!re));
   endtask

   task automatic step(input logic de_i, input logic txd_i, input int dv,
                       input logic op, input logic re_i, input int t);
      string rtag;
      @(negedge clk);
      de = de_i; txd = txd_i; diff_mv = 12'(dv); rx_open = op; re = re_i; temp_c = 8'(t);
      #1 check_comb();
      @(posedge clk);
      if (op)               begin exp_rx = 1'b1; rtag = "R6 rxd"; end
      else if (dv >= -30)   begin exp_rx = 1'b1; rtag = "R3 rxd"; end
      else if (dv <= -200)  begin exp_rx = 1'b0; rtag = "R4 rxd"; end
      else                  rtag = "R5 rxd hold";
      if (t >= 150)      exp_tsd = 1'b1;
      else if (t <= 140) exp_tsd = 1'b0;
      #1;
      chk(rtag, int'(rxd), int'(exp_rx));
      chk((t >= 150) ? "R8 tsd" : "R9 tsd", int'(tsd), int'(exp_tsd));
      check_comb();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      diff_mv = -12'sd250;
      temp_c = 8'd160;
      repeat (3) @(posedge clk);
      #1;
      chk("R11 tsd in reset", int'(tsd), 0);
      chk("R11 rxd in reset", int'(rxd), 1);
      @(negedge clk);
      diff_mv = '0; temp_c = 8'd25;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R11 tsd after reset", int'(tsd), 0);
      chk("R11 rxd after reset", int'(rxd), 1);

      // driver truth table, receiver idle at 0 V (R1, R2, R3)
      for (int i = 0; i < 4; i++) step(i[1], i[0], 0, 1'b0, 1'b0, 25);

      // threshold sweep from both prior states (R3, R4, R5)
      for (int v = -300; v <= 60; v++) begin
         step(v[0], v[1], 0, 1'b0, v[2], 30);
         step(1'b1, v[0], v, 1'b0, 1'b0, 30);
         step(1'b0, v[1], -250, 1'b0, v[3], 30);
         step(1'b1, v[0], v, 1'b0, 1'b0, 30);
      end

      // open inputs win over any voltage (R6)
      for (int v = -400; v <= 0; v += 50) begin
         step(1'b0, 1'b0, -250, 1'b0, 1'b0, 30);
         step(1'b0, 1'b0, v, 1'b1, 1'b0, 30);
      end

      // receiver tracks while disabled (R7)
      step(1'b0, 1'b0, 0, 1'b0, 1'b1, 30);
      step(1'b0, 1'b0, -250, 1'b0, 1'b1, 30);
      step(1'b0, 1'b0, -100, 1'b0, 1'b0, 30);

      // temperature ramp up and down, driver enabled (R8, R9, R10)
      for (int t = 120; t <= 170; t++) step(1'b1, t[0], t - 200, 1'b0, 1'b0, t);
      for (int t = 170; t >= 120; t--) step(1'b1, t[0], -t, 1'b0, 1'b0, t);
      // in-band excursion from clear state never trips (R9)
      for (int t = 141; t <= 149; t++) step(1'b1, 1'b1, 0, 1'b0, 1'b0, t);

      // concurrent: trip, threshold crossing and DE rise on one edge (R8, R4, R10)
      step(1'b0, 1'b1, 0, 1'b0, 1'b0, 100);
      step(1'b1, 1'b1, -200, 1'b0, 1'b0, 150);
      step(1'b1, 1'b0, -150, 1'b0, 1'b0, 145);
      // concurrent release and DE toggle (R9, R1, R3)
      step(1'b0, 1'b1, -30, 1'b0, 1'b0, 140);
      step(1'b1, 1'b1, -31, 1'b0, 1'b0, 140);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule